// File: doc/BRIEF.md
# Bootstrap Precharge Gate Sequencer

This block controls one half-bridge leg. It sits between a PWM command and the two gate requests that go on to a dead-time stage. A comparator outside the block raises a flag when the bootstrap supply of the high-side driver is too low, meaning the boot voltage is under 6.5 V. The block brings that flag into its clock domain through a synchronizer. While the supply is short, the block keeps the high-side request off.

In buck operation the capacitor only recharges when the low side conducts. So while the leg is held, the block stops normal switching. At each period-start strobe it issues one low-side pulse of fixed length, `PULSE_CYC` clocks long; 10 clocks at 100 MHz gives 100 ns. In boost operation the low side conducts every cycle anyway, so the block never inserts these pulses. The leg returns to normal switching at the first period-start strobe after the synchronized flag has cleared. If the flag rises during normal switching, the high side is cut off in that same cycle and the leg goes back to holding.

Top module: `boot_precharge_seq`

## Requirements
- R1: Reset is synchronous and active high. On reset the synchronized undervoltage flag is taken as set and the leg is held. In buck mode (`boost_mode`=0), `hs_req` and `ls_req` are both 0 from reset until the first period-start strobe.
- R2: While the leg is held, `hs_req` is 0 whatever the value of `pwm_cmd`.
- R3: In buck mode, if `period_start` is 1 at a clock edge while the leg is held and the synchronized flag is 1, then `ls_req` is 1 for exactly `PULSE_CYC` cycles, starting in the cycle after that edge. Apart from these pulses, `ls_req` is 0 while a buck leg is held.
- R4: `boot_uv_raw` passes through a two-stage synchronizer. A change on it driven before edge k is seen by the control logic from the cycle after edge k+1.
- R5: A held leg returns to normal switching at the first edge where `period_start` is 1 and the synchronized flag is 0. From the next cycle, `hs_req` follows `pwm_cmd`. In buck mode `ls_req` is then the inverse of `pwm_cmd`.
- R6: In normal switching, a synchronized flag of 1 forces `hs_req` to 0 in the same cycle. At the following edge the leg becomes held, and in buck mode the precharge pulses start again at the next strobe.
- R7: In boost mode no precharge pulse is produced. `ls_req` is always the inverse of `pwm_cmd`, and `hs_req` follows `pwm_cmd` only during normal switching.
- R8: `hs_req` and `ls_req` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_cmd | input | 1 | PWM command; 1 asks for the high side, 0 for the low side |
| period_start | input | 1 | One-cycle strobe at the start of each switching period |
| boost_mode | input | 1 | 1 selects boost operation, 0 selects buck operation |
| boot_uv_raw | input | 1 | Asynchronous bootstrap undervoltage flag, 1 = supply low |
| hs_req | output | 1 | High-side gate request |
| ls_req | output | 1 | Low-side gate request |

## Verification
Two things can compete for the same cycle: a precharge pulse that is still running, and a high-side request from the PWM command. The bench causes this by clearing the flag in the middle of a pulse and then raising `pwm_cmd`. At the strobe that ends the hold, the pulse is still counting down. The bench checks that `hs_req` stays low until the cycle after that strobe and that the pulse finishes on its own. It also raises the flag while `pwm_cmd` is high during normal switching. Here the high side must drop in the cycle the synchronized flag appears, and the low side must stay off until the next strobe. In every table cycle the bench also checks that the two requests are never both high.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic {
        LEG_HOLD = 1'b0,
        LEG_RUN  = 1'b1
    } leg_state_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_req_t;

    // Output routing: the high side needs normal switching and a healthy boot
    // supply; the low side follows the command, except in a held buck leg,
    // where only the recharge pulse may drive it.
    function automatic gate_req_t route_gates(
        input logic       boost,
        input leg_state_t state,
        input logic       pwm,
        input logic       uv_sync,
        input logic       pulse
    );
        gate_req_t g;
        g.hs = pwm && (state == LEG_RUN) && !uv_sync;
        if (!boost && state == LEG_HOLD)
            g.ls = pulse;
        else
            g.ls = !pwm;
        return g;
    endfunction

endpackage

// File: rtl/bps_uv_sync.sv
module bps_uv_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= 1'b1;   // assume a low supply until proven otherwise
                else if (i == 0)
                    chain[i] <= d_async;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bps_pulse_timer.sv
module bps_pulse_timer #(
    parameter int unsigned PULSE_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic active
);
    localparam int unsigned CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (launch)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);

    // The pulse ends on its own once the last count has run out.
    assert_pulse_ends_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(1) && !launch) |=> !active);

    // A launch always yields a pulse in the next cycle.
    assert_pulse_starts_R3: assert property (@(posedge clk) disable iff (rst)
        launch |=> active);
endmodule

// File: rtl/bps_leg_fsm.sv
module bps_leg_fsm
    import bps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic       uv_sync,
    output leg_state_t state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= LEG_HOLD;
        else begin
            case (state)
                LEG_HOLD: if (strobe && !uv_sync) state <= LEG_RUN;
                LEG_RUN:  if (uv_sync)            state <= LEG_HOLD;
                default:                          state <= LEG_HOLD;
            endcase
        end
    end

    // A held leg leaves only at a strobe with the supply restored.
    assert_hold_until_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (state == LEG_HOLD && !(strobe && !uv_sync)) |=> (state == LEG_HOLD));

    // Undervoltage during normal switching drops back to holding.
    assert_uv_reenters_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == LEG_RUN && uv_sync) |=> (state == LEG_HOLD));
endmodule

// File: rtl/boot_precharge_seq.sv
module boot_precharge_seq
    import bps_pkg::*;
#(
    parameter int unsigned PULSE_CYC   = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_cmd,
    input  logic period_start,
    input  logic boost_mode,
    input  logic boot_uv_raw,
    output logic hs_req,
    output logic ls_req
);
    logic       uv_sync;
    logic       pulse_on;
    logic       pulse_launch;
    leg_state_t leg_state;
    gate_req_t  gates;

    bps_uv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (boot_uv_raw),
        .q_sync  (uv_sync)
    );

    bps_leg_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .strobe  (period_start),
        .uv_sync (uv_sync),
        .state   (leg_state)
    );

    // Recharge pulses only in a held buck leg whose supply is still low.
    assign pulse_launch = !boost_mode && (leg_state == LEG_HOLD)
                        && period_start && uv_sync;

    bps_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .launch (pulse_launch),
        .active (pulse_on)
    );

    always_comb gates = route_gates(boost_mode, leg_state, pwm_cmd, uv_sync, pulse_on);

    assign hs_req = gates.hs;
    assign ls_req = gates.ls;

    assert_gates_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(hs_req && ls_req));

    assert_boost_no_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (boost_mode && pwm_cmd) |-> !ls_req);
endmodule

// File: tb/sim_boot_precharge_seq.sv
module sim_boot_precharge_seq;
    logic clk = 1'b0;
    logic rst, pwm, stb, boost, uv;
    logic hs, ls;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    boot_precharge_seq #(.PULSE_CYC(3), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .pwm_cmd(pwm), .period_start(stb),
        .boost_mode(boost), .boot_uv_raw(uv), .hs_req(hs), .ls_req(ls)
    );

    // Fields: req[3:0], pwm, stb, boost, uv, exp_hs, exp_ls.
    // Inputs are driven after a falling edge; outputs are checked before the next rising edge.
    localparam int NV = 27;
    localparam logic [9:0] TBL [NV] = '{
        10'b0010_1_0_0_1_0_0, // v0  R2 held after reset
        10'b0011_0_1_0_1_0_0, // v1  R3 strobe launches
        10'b0011_0_0_0_1_0_1, // v2  R3 pulse 1
        10'b0010_1_0_0_1_0_1, // v3  R2 pulse 2 with pwm high
        10'b0011_1_0_0_1_0_1, // v4  R3 pulse 3
        10'b0011_1_0_0_1_0_0, // v5  R3 pulse over
        10'b0011_0_1_0_0_0_0, // v6  R3 strobe, raw clears
        10'b0011_0_0_0_0_0_1, // v7  R3 pulse 1
        10'b0101_1_0_0_0_0_1, // v8  R5 cleared but waits for strobe
        10'b0101_0_1_0_0_0_1, // v9  R5 strobe ends hold, pulse finishing
        10'b0101_1_0_0_0_1_0, // v10 R5 hs follows pwm
        10'b0101_0_0_0_0_0_1, // v11 R5 ls inverse
        10'b0100_1_0_0_1_1_0, // v12 R4 raw rises
        10'b0100_1_0_0_1_1_0, // v13 R4 not yet seen
        10'b0110_1_0_0_1_0_0, // v14 R6 hs cut same cycle
        10'b0110_0_0_0_1_0_0, // v15 R6 held, switching stopped
        10'b0110_0_1_0_1_0_0, // v16 R6 strobe
        10'b0110_1_0_0_1_0_1, // v17 R6 pulses resume
        10'b0111_1_0_1_1_0_0, // v18 R7 boost pwm high
        10'b0111_0_0_1_1_0_1, // v19 R7 ls inverse
        10'b0111_0_1_1_1_0_1, // v20 R7 strobe, no launch
        10'b0111_1_0_1_1_0_0, // v21 R7 no pulse
        10'b0111_1_0_1_0_0_0, // v22 R7 raw clears
        10'b0111_1_0_1_0_0_0, // v23 R7
        10'b0111_1_1_1_0_0_0, // v24 R7 strobe ends hold
        10'b0111_1_0_1_0_1_0, // v25 R7 hs follows
        10'b0111_0_0_1_0_0_1  // v26 R7 ls inverse
    };

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1..: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pwm = 1'b0; stb = 1'b0; boost = 1'b0; uv = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state, buck, no strobe yet
        #1;
        check("R1", hs, 1'b0, "hs after reset");
        check("R1", ls, 1'b0, "ls after reset");
        @(posedge clk);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {pwm, stb, boost, uv} = TBL[i][5:2];
            #1;
            check($sformatf("R%0d v%0d", TBL[i][9:6], i), hs, TBL[i][1], "hs_req");
            check($sformatf("R%0d v%0d", TBL[i][9:6], i), ls, TBL[i][0], "ls_req");
            check($sformatf("R8 v%0d", i), hs & ls, 1'b0, "overlap");
        end
        // R1 reset in the middle of normal switching with a healthy supply
        @(negedge clk);
        boost = 1'b0; pwm = 1'b1; stb = 1'b0; uv = 1'b0; rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        #1 check("R1", hs, 1'b0, "hs after mid-run reset");
        check("R1", ls, 1'b0, "ls after mid-run reset");
        repeat (3) @(negedge clk);
        #1 check("R5", hs, 1'b0, "hs before strobe after reset");
        @(negedge clk) stb = 1'b1;
        @(negedge clk) stb = 1'b0;
        #1 check("R5", hs, 1'b1, "hs after strobe");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule